// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Register

This block is the data path of a small 8-bit RISC core: a combinational arithmetic/logic unit that turns two operands, a carry input and an operation code into a result and a fresh set of condition flags, together with the status register that holds those flags between instructions. The status register has eight bits. From bit 7 down to bit 0 they are: global interrupt enable I, bit-transfer T, half carry H, sign S, two's-complement overflow V, negative N, zero Z and carry C.

Each operation writes its own fixed subset of the flags and leaves the others as they were. The unit drives a write mask with this subset, and it also drives `status_next`, which is the status register with the masked flags already replaced. When `flag_we` is high, the register takes `status_next` on the clock edge. A full-register load path lets the core restore or write the whole status byte, including I and T. The sign flag S always equals N XOR V, so that signed greater-or-equal and less-than branches can test S directly.

The data width is the parameter `WIDTH`, which defaults to 8. H is the carry or borrow out of the lower half of the word, and SWAP exchanges the two halves.

Top module: `risc_alu_status`

## Requirements
- R1: Opcode 0 (add) gives a+b and opcode 1 (add with carry) gives a+b+carry_in. Both write H, S, V, N, Z and C, giving mask 0x3F. C is the carry out of the top bit, H is the carry out of the lower half, and V is set when the signed sum leaves the signed range.
- R2: Opcode 2 (subtract) gives a-b and opcode 3 (subtract with carry) gives a-b-carry_in. Both use mask 0x3F, with C and H as borrows and V as signed overflow. For opcode 3, Z becomes 0 when the result is nonzero and otherwise keeps its stored value.
- R3: Whenever an operation writes N, the value it writes to S (bit 4) equals N XOR V.
- R4: Opcodes 4 (AND), 5 (OR) and 6 (XOR) write only S, V, N and Z (mask 0x1E). V becomes 0, and C and H keep their stored values.
- R5: Opcode 9 (increment) and opcode 10 (decrement) use mask 0x1E. V is set only when the result crosses between the largest positive value and the most negative value.
- R6: Opcode 7 (one's complement) gives the all-ones value minus a and uses mask 0x1F. It forces C to 1 and V to 0.
- R7: Opcode 8 (two's complement) gives 0 minus a and uses mask 0x3F. C is set when the result is nonzero, and V is set only for the most negative value.
- R8: Opcode 11 (shift left) fills bit 0 with 0 and opcode 12 (logical shift right) fills the top bit with 0. C takes the bit shifted out, V = N XOR C, the mask is 0x1F, and H is kept.
- R9: Opcode 13 (rotate left) moves carry_in into bit 0 and the top bit into C. Opcode 14 (rotate right) moves carry_in into the top bit and bit 0 into C. Both use mask 0x1F with V = N XOR C.
- R10: Opcode 15 (arithmetic shift right) keeps the top bit, shifts the bits down, puts bit 0 into C, and uses mask 0x1F.
- R11: Opcode 16 (swap) exchanges the upper and lower halves of a and changes no flag (mask 0x00).
- R12: On a clock edge with flag_we high and load_en low, the status register takes status_next, so only the masked flags change. I and T are never altered by an operation.
- R13: Reset clears the status register to 0x00. On a clock edge with load_en high, the register takes load_val, and this load has priority over flag_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 5 | Operation code |
| a | input | WIDTH | First operand (destination register value) |
| b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry used by add/subtract with carry and rotates |
| flag_we | input | 1 | Commit the operation's flags to the status register |
| load_en | input | 1 | Load the whole status register |
| load_val | input | 8 | Value for a full status register load |
| result | output | WIDTH | Operation result |
| flag_mask | output | 8 | Flags written by the current operation |
| status_next | output | 8 | Status register with the masked flags updated |
| status | output | 8 | Stored status register |

## Verification
The bench builds the unit with WIDTH set to 4. This makes the half-carry boundary a 2-bit boundary and the signed range -8 to 7, so that every operand pair, both carry inputs and both stored Z values can be applied to every opcode. The sweep therefore covers every carry, borrow and overflow corner, including the most-negative two's complement and the increment and decrement wrap points. For each vector, the bench first loads the status register with a pattern that varies I and T. It then checks both the combinational outputs and the value committed on the next edge.

// File: rtl/risc_alu_status.sv
module risc_alu_status #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_in,
  input  logic             flag_we,
  input  logic             load_en,
  input  logic [7:0]       load_val,
  output logic [WIDTH-1:0] result,
  output logic [7:0]       flag_mask,
  output logic [7:0]       status_next,
  output logic [7:0]       status
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MOST_POS = {1'b0, {(WIDTH-1){1'b1}}};

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7;
  localparam logic [4:0] OP_NEG = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11;
  localparam logic [4:0] OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15;
  localparam logic [4:0] OP_SWP = 5'd16;

  localparam logic [7:0] M_ARITH = 8'h3F;
  localparam logic [7:0] M_LOGIC = 8'h1E;
  localparam logic [7:0] M_SHIFT = 8'h1F;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   add_w, sub_w;
  logic [HALF:0]    add_h, sub_h;

  assign x   = (op == OP_NEG) ? '0 : a;
  assign y   = (op == OP_NEG) ? a  : b;
  assign cin = (op == OP_ADC || op == OP_SBC) ? carry_in : 1'b0;

  assign add_w = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign sub_w = {1'b0, x} - {1'b0, y} - {{WIDTH{1'b0}}, cin};
  assign add_h = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
  assign sub_h = {1'b0, x[HALF-1:0]} - {1'b0, y[HALF-1:0]} - {{HALF{1'b0}}, cin};

  logic [WIDTH-1:0] res;
  logic             c_f, h_f, v_f, n_f, z_f;
  logic [7:0]       mask;

  always_comb begin
    res  = a;
    c_f  = 1'b0;
    h_f  = 1'b0;
    v_f  = 1'b0;
    mask = 8'h00;
    case (op)
      OP_ADD, OP_ADC: begin
        res  = add_w[MSB:0];
        c_f  = add_w[WIDTH];
        h_f  = add_h[HALF];
        v_f  = (x[MSB] == y[MSB]) && (res[MSB] != x[MSB]);
        mask = M_ARITH;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        res  = sub_w[MSB:0];
        c_f  = sub_w[WIDTH];
        h_f  = sub_h[HALF];
        v_f  = (x[MSB] != y[MSB]) && (res[MSB] != x[MSB]);
        mask = M_ARITH;
      end
      OP_AND: begin res = a & b; mask = M_LOGIC; end
      OP_OR:  begin res = a | b; mask = M_LOGIC; end
      OP_XOR: begin res = a ^ b; mask = M_LOGIC; end
      OP_COM: begin res = ~a; c_f = 1'b1; mask = M_SHIFT; end
      OP_INC: begin res = a + 1'b1; v_f = (res == MOST_NEG); mask = M_LOGIC; end
      OP_DEC: begin res = a - 1'b1; v_f = (res == MOST_POS); mask = M_LOGIC; end
      OP_LSL: begin res = {a[MSB-1:0], 1'b0};     c_f = a[MSB]; mask = M_SHIFT; end
      OP_LSR: begin res = {1'b0, a[MSB:1]};       c_f = a[0];   mask = M_SHIFT; end
      OP_ROL: begin res = {a[MSB-1:0], carry_in}; c_f = a[MSB]; mask = M_SHIFT; end
      OP_ROR: begin res = {carry_in, a[MSB:1]};   c_f = a[0];   mask = M_SHIFT; end
      OP_ASR: begin res = {a[MSB], a[MSB:1]};     c_f = a[0];   mask = M_SHIFT; end
      OP_SWP: res = {a[HALF-1:0], a[MSB:HALF]};
      default: ;
    endcase
    if (op == OP_LSL || op == OP_LSR || op == OP_ROL || op == OP_ROR || op == OP_ASR)
      v_f = res[MSB] ^ c_f;
  end

  assign n_f = res[MSB];
  assign z_f = (res == '0) && (op != OP_SBC || status[1]);

  logic [7:0] fresh;
  assign fresh       = {2'b00, h_f, n_f ^ v_f, v_f, n_f, z_f, c_f};
  assign result      = res;
  assign flag_mask   = mask;
  assign status_next = (status & ~mask) | (fresh & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status <= 8'h00;
    else if (load_en) status <= load_val;
    else if (flag_we) status <= status_next;
  end

  a_r3_sign_is_n_xor_v: assert property (@(posedge clk) disable iff (!rst_n)
    flag_mask[2] |-> status_next[4] == (status_next[2] ^ status_next[3]));
  a_r4_logic_keeps_c_h: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_AND || op == OP_OR || op == OP_XOR) |->
      (status_next[5] == status[5] && status_next[0] == status[0] && !status_next[3]));
  a_r11_swap_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SWP) |-> status_next == status);
  a_r12_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !load_en) |=> status == $past(status_next));
  a_r12_it_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> status[7:6] == $past(status[7:6]));
  a_r13_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> status == $past(load_val));
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_mask[1] && op != OP_SBC) |-> status_next[1] == (result == '0));
endmodule

// File: tb/risc_alu_status_test.sv
module risc_alu_status_test;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic carry_in = 1'b0, flag_we = 1'b0, load_en = 1'b0;
  logic [7:0] load_val = '0;
  logic [W-1:0] result;
  logic [7:0] flag_mask, status_next, status;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  risc_alu_status #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .carry_in(carry_in),
    .flag_we(flag_we), .load_en(load_en), .load_val(load_val),
    .result(result), .flag_mask(flag_mask), .status_next(status_next), .status(status));

  always #(CLK_P/2) clk = ~clk;

  function automatic int sx(int v);
    return (v > 7) ? v - 16 : v;
  endfunction

  function automatic string req_of(int o);
    case (o)
      0, 1:     return "R1";
      2, 3:     return "R2";
      4, 5, 6:  return "R4";
      7:        return "R6";
      8:        return "R7";
      9, 10:    return "R5";
      11, 12:   return "R8";
      13, 14:   return "R9";
      15:       return "R10";
      default:  return "R11";
    endcase
  endfunction

  // returns {result[3:0], next status[7:0], mask[7:0]}
  function automatic logic [19:0] model(int o, int x0, int y0, int ci, logic [7:0] s);
    int r = 0, c = 0, h = 0, v = 0, n, z, msk = 0, t, sv, x, y, cc;
    logic [7:0] f;
    case (o)
      0, 1: begin
        cc = (o == 1) ? ci : 0;
        t = x0 + y0 + cc; r = t & 15; c = int'(t > 15);
        h = int'(((x0 & 3) + (y0 & 3) + cc) > 3);
        sv = sx(x0) + sx(y0) + cc; v = int'(sv > 7 || sv < -8); msk = 'h3F;
      end
      2, 3, 8: begin
        x = (o == 8) ? 0 : x0; y = (o == 8) ? x0 : y0; cc = (o == 3) ? ci : 0;
        t = x - y - cc; r = t & 15; c = int'(t < 0);
        h = int'(((x & 3) - (y & 3) - cc) < 0);
        sv = sx(x) - sx(y) - cc; v = int'(sv > 7 || sv < -8); msk = 'h3F;
      end
      4: begin r = x0 & y0; msk = 'h1E; end
      5: begin r = x0 | y0; msk = 'h1E; end
      6: begin r = x0 ^ y0; msk = 'h1E; end
      7: begin r = 15 - x0; c = 1; msk = 'h1F; end
      9: begin r = (x0 + 1) & 15; v = int'(x0 == 7); msk = 'h1E; end
      10: begin r = (x0 + 15) & 15; v = int'(x0 == 8); msk = 'h1E; end
      11: begin r = (x0 * 2) & 15;            c = x0 >> 3; end
      12: begin r = x0 >> 1;                  c = x0 & 1;  end
      13: begin r = ((x0 * 2) & 15) | ci;     c = x0 >> 3; end
      14: begin r = (x0 >> 1) | (ci * 8);     c = x0 & 1;  end
      15: begin r = (x0 >> 1) | (x0 & 8);     c = x0 & 1;  end
      default: r = ((x0 & 3) << 2) | (x0 >> 2);
    endcase
    n = (r >> 3) & 1;
    if (o >= 11 && o <= 15) begin v = n ^ c; msk = 'h1F; end
    z = int'(r == 0);
    if (o == 3) z = z & int'(s[1]);
    f = {2'b00, h[0], n[0] ^ v[0], v[0], n[0], z[0], c[0]};
    return {r[3:0], (s & ~msk[7:0]) | (f & msk[7:0]), msk[7:0]};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (op %0d a %0d b %0d cin %0d)",
               req, what, act, exp, op, a, b, carry_in);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [19:0] m;
    logic [7:0] pre;
    #(CLK_P * 2 + 2);
    check("R13", status, 8'h00, "reset value");
    @(negedge clk); rst_n = 1'b1;
    // load wins over flag write (R13)
    load_en = 1'b1; flag_we = 1'b1; load_val = 8'hC5; op = 5'd0; a = 4'd0; b = 4'd0;
    @(negedge clk);
    check("R13", status, 8'hC5, "load priority");
    load_en = 1'b0; flag_we = 1'b0;
    for (int o = 0; o <= 16; o++)
      for (int zi = 0; zi < 2; zi++)
        for (int ci = 0; ci < 2; ci++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
              pre = 8'((x * 37 + y * 11 + o * 5 + ci * 64) & 'hFD) | 8'(zi << 1);
              load_en = 1'b1; flag_we = 1'b0; load_val = pre;
              @(negedge clk);
              load_en = 1'b0; flag_we = 1'b1;
              op = 5'(o); a = 4'(x); b = 4'(y); carry_in = 1'(ci);
              #1;
              m = model(o, x, y, ci, pre);
              check(req_of(o), 8'(result), 8'(m[19:16]), "result");
              check(req_of(o), flag_mask, m[7:0], "flag mask");
              check(req_of(o), status_next, m[15:8], "status_next");
              if (flag_mask[2]) check("R3", 8'(status_next[4]), 8'(status_next[2] ^ status_next[3]), "S=N^V");
              @(negedge clk);
              check("R12", status, m[15:8], "committed status");
              check("R12", 8'(status[7:6]), 8'(pre[7:6]), "I/T kept");
            end
    flag_we = 1'b0;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule